// File: doc/BRIEF.md
# I2C Target Register Read Engine

This block sits on a two-wire serial bus as a target device and answers combined-format reads from a small register bank held outside it. A read always comes in two phases. The controller first addresses the device for writing and sends one subaddress byte. It then issues a repeated start, addresses the device again with the read bit set, and clocks data bytes out of the target. Each byte sent advances an internal pointer by one, wrapping at the top of the bank. The stream ends when the controller answers a byte with a not-acknowledge, and a stop condition then follows.

Both bus lines pass through a synchroniser and are sampled on the system clock, which must run at least eight times faster than SCL. The target never stretches the clock. Its only drive onto the bus is an open-drain pull-low request. The register bank is reached through a plain read port with no handshake. `rd_addr_o` always shows the current pointer, and the bank must return the matching byte on `rd_data_i` combinationally in the same cycle. There is no back-pressure, because the bus cannot be stalled. The byte is captured on the SCL falling edge that starts its first bit.

Top module: `i2c_rd_engine`

## Requirements
- R1: While reset is held and after it is released, the target does not pull SDA low, and `rd_addr_o` reads 0.
- R2: A byte that follows a start condition and whose bits 7:1 (MSB first on the bus) equal the device address parameter is acknowledged: the target pulls SDA low for the ninth clock. Bit 0 of that byte is the read/write bit, where 1 means read.
- R3: In the write phase, the byte that follows the acknowledged address byte is a subaddress, sent MSB first. The target acknowledges it and loads its low AW bits into the pointer, so a subaddress is taken modulo the bank size.
- R4: After a repeated start, an address byte that matches and has its read bit set is acknowledged.
- R5: After the read-address acknowledge, the target shifts out the register at the pointer MSB first, one bit per SCL low phase.
- R6: Every byte that is loaded for transmission advances the pointer by one, modulo 2^AW. When the controller acknowledges a byte, the next byte comes from the next address, wrapping from the top of the bank to 0.
- R7: When the controller does not acknowledge a data byte, the target releases SDA and sends nothing more until the next start condition.
- R8: If the address bits do not match, the target gives no acknowledge and keeps SDA released for every following bit until the next start or stop.
- R9: A start or stop condition in the middle of a byte aborts the current transfer. After a start, the target matches a fresh address byte.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release it |
| rd_addr_o | output | AW | Register bank read address (the pointer) |
| rd_data_i | input | 8 | Register byte at `rd_addr_o`, valid in the same cycle |

## Verification
Reads are run with a single byte, with a stream of three bytes starting mid-bank, with a stream that crosses the top of the bank, and with a subaddress wider than the bank. Together these separate a correct pointer load from a pointer that only increments, and a correct wrap from an overflow. A wrong-address pass in both directions shows that a non-matching target leaves the line alone, even across data bits where it would otherwise drive. Transfers cut short by a start and by a stop, each followed by a clean read, show that an abort drops partial bits and does not shift later bytes.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_ACK,
    ST_TX,
    ST_MACK
  } rd_state_t;

  typedef enum logic [1:0] {
    AK_WR,
    AK_SUB,
    AK_RD
  } ack_kind_t;
endpackage

// File: rtl/i2c_rd_sampler.sv
module i2c_rd_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] scl_ff;
  logic [LAST:0] sda_ff;
  logic          scl_q;
  logic          sda_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[LAST-1:0], scl_i};
          sda_ff <= {sda_ff[LAST-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[LAST];
      sda_q <= sda_ff[LAST];
    end
  end

  assign scl_s    = scl_ff[LAST];
  assign sda_s    = sda_ff[LAST];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          sda_low
);
  localparam logic [3:0]    BITS_PER_BYTE = 4'd8;
  localparam logic [3:0]    LAST_TX_BIT   = 4'd7;
  localparam logic [AW-1:0] PTR_ONE       = {{(AW-1){1'b0}}, 1'b1};

  rd_state_t     st;
  ack_kind_t     ak;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    txreg;
  logic [AW-1:0] ptr;
  logic          mack;
  logic          sda_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ak        <= AK_WR;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      ptr       <= '0;
      mack      <= 1'b0;
      sda_low_q <= 1'b0;
    end else if (stop_p) begin
      st        <= ST_IDLE;
      sda_low_q <= 1'b0;
    end else if (start_p) begin
      st        <= ST_ADDR;
      bitcnt    <= '0;
      sda_low_q <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_SUB: begin
          if (scl_rise && bitcnt < BITS_PER_BYTE) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == BITS_PER_BYTE) begin
            if (st == ST_SUB) begin
              ptr       <= shreg[AW-1:0];
              ak        <= AK_SUB;
              st        <= ST_ACK;
              sda_low_q <= 1'b1;
            end else if (shreg[7:1] == DEV_ADDR) begin
              ak        <= shreg[0] ? AK_RD : AK_WR;
              st        <= ST_ACK;
              sda_low_q <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt    <= '0;
            sda_low_q <= 1'b0;
            unique case (ak)
              AK_WR:   st <= ST_SUB;
              AK_SUB:  st <= ST_IDLE;
              default: begin
                st        <= ST_TX;
                txreg     <= rd_data;
                sda_low_q <= ~rd_data[7];
                ptr       <= ptr + PTR_ONE;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_TX_BIT) begin
              st        <= ST_MACK;
              sda_low_q <= 1'b0;
            end else begin
              txreg     <= {txreg[6:0], 1'b0};
              sda_low_q <= ~txreg[6];
              bitcnt    <= bitcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st        <= ST_TX;
              bitcnt    <= '0;
              txreg     <= rd_data;
              sda_low_q <= ~rd_data[7];
              ptr       <= ptr + PTR_ONE;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr = ptr;
  assign sda_low = sda_low_q;

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_q) |-> (!$past(scl_s) || $past(start_p) || $past(stop_p)));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && $past(st) != ST_TX) |-> ptr == $past(ptr) + PTR_ONE);

  // R8
  no_ack_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && scl_fall && bitcnt == BITS_PER_BYTE && shreg[7:1] != DEV_ADDR
     && !start_p && !stop_p) |=> (st == ST_IDLE && !sda_low_q));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !stop_p) |=> (st == ST_ADDR && bitcnt == 4'd0 && !sda_low_q));

  // R7
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !sda_low_q);
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine #(
  parameter logic [6:0]  DEV_ADDR    = 7'h2A,
  parameter int unsigned AW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_low_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  logic scl_s;
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_p;
  logic stop_p;

  i2c_rd_sampler #(
    .STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  i2c_rd_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .AW      (AW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rd_data  (rd_data_i),
    .rd_addr  (rd_addr_o),
    .sda_low  (sda_low_o)
  );
endmodule

// File: tb/i2c_rd_engine_bench.sv
module i2c_rd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10 * CLK_PERIOD;
  localparam logic [6:0] DEV = 7'h2A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_low;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_bus;

  int tests = 0;
  int fails = 0;
  int viol  = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_byte;
  string      cur_tag;
  event       got_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bank(input logic [3:0] a);
    return ({4'd0, a} * 8'd37) + 8'd11;
  endfunction

  assign rd_data = bank(rd_addr);
  assign sda_bus = sda_m & ~sda_low;

  i2c_rd_engine #(.DEV_ADDR(DEV), .AW(4), .SYNC_STAGES(2)) u_i2c_rd_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_low_o (sda_low),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10 watch: drive must not move while raw SCL stays high
  logic scl_prev = 1'b1;
  logic low_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && (sda_low !== low_prev)) viol++;
    scl_prev <= scl;
    low_prev <= sda_low;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk({cur_tag, " unexpected byte"}, obs_byte, 8'hxx);
      else chk(cur_tag, obs_byte, exp_q.pop_front());
    end
  end

  task automatic bus_bit(input logic v, output logic s);
    #Q sda_m = v;
    #Q scl = 1'b1;
    #Q s = sda_bus;
    #Q scl = 1'b0;
  endtask

  task automatic do_start;
    #Q sda_m = 1'b1;
    #Q scl = 1'b1;
    #Q sda_m = 1'b0;
    #Q scl = 1'b0;
  endtask

  task automatic do_stop;
    #Q sda_m = 1'b0;
    #Q scl = 1'b1;
    #Q sda_m = 1'b1;
    #Q;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    logic [7:0] t;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      t[i] = s;
    end
    bus_bit(~give_ack, s);
    b = t;
  endtask

  task automatic read_seq(input logic [7:0] sub, input int n, input string tag);
    logic a;
    logic [7:0] b;
    do_start();
    wr_byte({DEV, 1'b0}, a);
    chk("R2 write-address ack", {7'd0, a}, 8'd1);
    wr_byte(sub, a);
    chk("R3 subaddress ack", {7'd0, a}, 8'd1);
    do_start();
    wr_byte({DEV, 1'b1}, a);
    chk("R4 read-address ack", {7'd0, a}, 8'd1);
    cur_tag = tag;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(bank(4'(sub + 8'(k))));
      rd_byte(k != n - 1, b);
      obs_byte = b;
      -> got_ev;
    end
    #Q chk("R7 released after NACK", {7'd0, sda_low}, 8'd0);
    do_stop();
    chk("R7 queue drained", 8'(exp_q.size()), 8'd0);
  endtask

  initial begin
    logic a;
    logic s;
    logic [7:0] b;
    #(3 * CLK_PERIOD);
    @(negedge clk);
    chk("R1 SDA released in reset", {7'd0, sda_low}, 8'd0);
    rst_n = 1'b1;
    #(4 * CLK_PERIOD);
    chk("R1 SDA released after reset", {7'd0, sda_low}, 8'd0);
    chk("R1 pointer zero", {4'd0, rd_addr}, 8'd0);

    read_seq(8'h03, 1, "R5 single byte");
    read_seq(8'h07, 3, "R6 stream");
    read_seq(8'h0E, 4, "R6 wrap");
    read_seq(8'h25, 2, "R6 wide subaddress");

    // R8: foreign address, write then read direction
    do_start();
    wr_byte({7'h11, 1'b0}, a);
    chk("R8 no ack on mismatch", {7'd0, a}, 8'd0);
    wr_byte(8'h00, a);
    chk("R8 no ack on later byte", {7'd0, a}, 8'd0);
    do_start();
    wr_byte({7'h11, 1'b1}, a);
    chk("R8 no ack on read mismatch", {7'd0, a}, 8'd0);
    rd_byte(1'b1, b);
    chk("R8 line stays released", b, 8'hFF);
    do_stop();

    // R9: start mid-subaddress, then stop mid-subaddress
    do_start();
    wr_byte({DEV, 1'b0}, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    read_seq(8'h09, 2, "R9 after start abort");
    do_start();
    wr_byte({DEV, 1'b0}, a);
    for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
    do_stop();
    read_seq(8'h0C, 1, "R9 after stop abort");

    tests++;
    if (viol != 0) begin
      fails++;
      $display("FAIL R10 actual=%0d expected=0 drive changes with SCL high", viol);
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule